// File: doc/BRIEF.md
# Adaptive Traffic Phase Decision Unit

This unit decides when an intersection controller should leave its current signal phase. It keeps a vehicle count for each of two arms, raised by entry-sensor pulses and lowered by exit-sensor pulses, and it measures how long the current phase has lasted by counting tick pulses. A separate light-sequencing state machine tells it which kind of phase is active (green, red-plus-left arrow, pedestrian) and which arm that phase favours. The unit answers with a one-cycle switch request.

Each phase kind is bounded by a minimum and a maximum time. Between the two bounds a phase ends early on queue evidence: the favoured arm's queue is empty, a weighted queue balance has dropped to zero or below, or the favoured queue has not moved for a fixed number of ticks. The weights (a per-arm gain and offset) arrive as signed fixed-point configuration inputs, so the unit never divides. It has no lamp outputs.

Top module: `phase_decider`

## Requirements
- R1: An entry pulse on an arm raises that arm's count by one and an exit pulse lowers it by one; both in the same cycle leave it unchanged. The new count appears on count0_o/count1_o (arm 0/arm 1) on the clock edge that samples the pulse.
- R2: A count holds at 0 on an exit pulse and holds at 2^CNT_W-1 on an entry pulse.
- R3: The elapsed time T rises by one per cycle with tick_i high. switch_o is registered: it goes high one cycle after the clock edge where the switch condition becomes true, it stays high for exactly one cycle, and T then restarts from zero.
- R4: With phase_i = 0 (green), no switch is raised while T is below the favoured arm's minimum (min0_i when fav_i = 0, min1_i when fav_i = 1), unless R5 applies.
- R5: With phase_i = 0, a switch is forced once T is at or above the favoured arm's maximum (max0_i/max1_i); with phase_i = 1 (red plus left arrow) the same holds for max_left_i.
- R6: In phase 0 or 1, with T between minimum and maximum, a switch is raised when the favoured arm's count is zero.
- R7: In phase 0, with T between the bounds, a switch is raised when f = alpha*n_fav + beta - n_other <= 0. alpha and beta are the favoured arm's alpha0_i/beta0_i or alpha1_i/beta1_i, two's complement with 4 fractional bits (16 means 1.0). f is exact and cannot overflow.
- R8: In phase 0 or 1, with T between the bounds, a switch is raised once STALL_TICKS (default 5) ticks have passed with no change of the favoured arm's count. The stall timer restarts whenever that count changes, on a switch and on clear.
- R9: Phase 1 uses min_left_i and max_left_i instead of the per-arm bounds, and the weighted rule of R7 does not apply there.
- R10: With phase_i = 2 (pedestrian) or 3, the only switch cause is T at or above max_ped_i.
- R11: rst_ni (asynchronous, active low) and clear_i (synchronous) zero both counts, T, the stall timer and switch_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of counts and timers |
| tick_i | input | 1 | Time-unit enable |
| enter_i | input | 2 | Entry-sensor pulse per arm (bit 0 = arm 0) |
| leave_i | input | 2 | Exit-sensor pulse per arm |
| phase_i | input | 2 | 0 green, 1 red plus left arrow, 2/3 pedestrian |
| fav_i | input | 1 | Favoured arm of the current phase |
| alpha0_i | input | COEF_W | Arm 0 queue gain, Q4 signed |
| alpha1_i | input | COEF_W | Arm 1 queue gain, Q4 signed |
| beta0_i | input | COEF_W | Arm 0 offset, Q4 signed |
| beta1_i | input | COEF_W | Arm 1 offset, Q4 signed |
| min0_i | input | T_W | Arm 0 green minimum time |
| max0_i | input | T_W | Arm 0 green maximum time |
| min1_i | input | T_W | Arm 1 green minimum time |
| max1_i | input | T_W | Arm 1 green maximum time |
| min_left_i | input | T_W | Left-arrow phase minimum time |
| max_left_i | input | T_W | Left-arrow phase maximum time |
| max_ped_i | input | T_W | Pedestrian phase duration |
| switch_o | output | 1 | One-cycle request to leave the phase |
| count0_o | output | CNT_W | Arm 0 vehicle count |
| count1_o | output | CNT_W | Arm 1 vehicle count |

## Verification
The bench walks a table of weight and queue settings whose balance f lands just above, exactly at and below zero, with negative gains and offsets and with either arm favoured. A sign or scaling slip in the fixed-point sum would show up here as a missing or extra request at the minimum time. Directed cases probe the timing bounds. A request one tick before the minimum or after the maximum means a wrong comparison. A stall request that still arrives after the favoured count moved means the stall timer missed its restart. A left-arrow phase that switches on the green bounds or on the weighted rule means the wrong phase was decoded. Counting past zero or past full would show as a wrapped count.

// File: rtl/phase_pkg.sv
package phase_pkg;
  typedef enum logic [1:0] {
    PH_GREEN = 2'd0,
    PH_LEFT  = 2'd1,
    PH_PED   = 2'd2,
    PH_PED_X = 2'd3
  } phase_e;
endpackage

// File: rtl/arm_counter.sv
module arm_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             enter_i,
  input  logic             leave_i,
  output logic [CNT_W-1:0] count_o,
  output logic             changed_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (enter_i && !leave_i && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    else if (leave_i && !enter_i && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    if (clear_i) cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o   = cnt_q;
  assign changed_o = (cnt_d != cnt_q);

  p_inc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && enter_i && !leave_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_both_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && enter_i && leave_i) |=> $stable(cnt_q));
  p_floor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && leave_i && !enter_i) |=> cnt_q == '0);
  p_ceil_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && cnt_q == CNT_MAX && enter_i && !leave_i) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int T_W         = 8,
  parameter int STALL_TICKS = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic           tick_i,
  input  logic           restart_i,
  input  logic           fav_chg_i,
  output logic [T_W-1:0] t_o,
  output logic           stall_o
);
  localparam int S_W = $clog2(STALL_TICKS + 1);
  localparam logic [S_W-1:0] S_LIM = S_W'(STALL_TICKS);
  localparam logic [T_W-1:0] T_MAX = '1;

  logic [T_W-1:0] t_q;
  logic [S_W-1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q <= '0;
      s_q <= '0;
    end else begin
      if (clear_i || restart_i)     t_q <= '0;
      else if (tick_i && t_q != T_MAX) t_q <= t_q + 1'b1;

      if (clear_i || restart_i || fav_chg_i) s_q <= '0;
      else if (tick_i && s_q != S_LIM)       s_q <= s_q + 1'b1;
    end
  end

  assign t_o     = t_q;
  assign stall_o = (s_q == S_LIM);

  p_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> t_q == '0);
  p_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !restart_i && !tick_i) |=> $stable(t_q));
  p_stall_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fav_chg_i |=> !stall_o);
endmodule

// File: rtl/switch_logic.sv
module switch_logic
  import phase_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int T_W    = 8,
  parameter int COEF_W = 8,
  parameter int FRAC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [1:0]        phase_i,
  input  logic              fav_i,
  input  logic [T_W-1:0]    t_i,
  input  logic              stall_i,
  input  logic [CNT_W-1:0]  n0_i,
  input  logic [CNT_W-1:0]  n1_i,
  input  logic [COEF_W-1:0] alpha0_i,
  input  logic [COEF_W-1:0] alpha1_i,
  input  logic [COEF_W-1:0] beta0_i,
  input  logic [COEF_W-1:0] beta1_i,
  input  logic [T_W-1:0]    min0_i,
  input  logic [T_W-1:0]    max0_i,
  input  logic [T_W-1:0]    min1_i,
  input  logic [T_W-1:0]    max1_i,
  input  logic [T_W-1:0]    min_left_i,
  input  logic [T_W-1:0]    max_left_i,
  input  logic [T_W-1:0]    max_ped_i,
  output logic              switch_o
);
  // room for gain*count, offset and scaled opposing count
  localparam int ACC_W = COEF_W + CNT_W + FRAC_W + 2;

  phase_e ph;
  logic [CNT_W-1:0]  n_fav, n_oth;
  logic [COEF_W-1:0] a_sel, b_sel;
  logic [T_W-1:0]    min_g, max_g;
  logic signed [ACC_W-1:0] a_x, n_x, b_x, o_x, f_val;
  logic f_le0, fav_zero, want, sw_q;

  assign ph    = phase_e'(phase_i);
  assign n_fav = fav_i ? n1_i : n0_i;
  assign n_oth = fav_i ? n0_i : n1_i;
  assign a_sel = fav_i ? alpha1_i : alpha0_i;
  assign b_sel = fav_i ? beta1_i : beta0_i;
  assign min_g = fav_i ? min1_i : min0_i;
  assign max_g = fav_i ? max1_i : max0_i;

  always_comb begin
    a_x   = {{(ACC_W-COEF_W){a_sel[COEF_W-1]}}, a_sel};
    b_x   = {{(ACC_W-COEF_W){b_sel[COEF_W-1]}}, b_sel};
    n_x   = {{(ACC_W-CNT_W){1'b0}}, n_fav};
    o_x   = {{(ACC_W-CNT_W-FRAC_W){1'b0}}, n_oth, {FRAC_W{1'b0}}};
    f_val = a_x * n_x + b_x - o_x;
  end

  assign f_le0    = f_val[ACC_W-1] || (f_val == '0);
  assign fav_zero = (n_fav == '0);

  always_comb begin
    unique case (ph)
      PH_GREEN: want = (t_i >= max_g) ||
                       ((t_i >= min_g) && (fav_zero || f_le0 || stall_i));
      PH_LEFT:  want = (t_i >= max_left_i) ||
                       ((t_i >= min_left_i) && (fav_zero || stall_i));
      default:  want = (t_i >= max_ped_i);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sw_q <= 1'b0;
    else if (clear_i) sw_q <= 1'b0;
    else              sw_q <= want && !sw_q;
  end

  assign switch_o = sw_q;

  p_one_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_q |=> !sw_q);
  p_min_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph == PH_GREEN && t_i < min_g && t_i < max_g) |-> !want);
  p_force_max_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph == PH_GREEN && t_i >= max_g && !sw_q && !clear_i) |=> sw_q);
  p_ped_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i[1] && t_i < max_ped_i) |-> !want);
  p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !sw_q);
endmodule

// File: rtl/phase_decider.sv
module phase_decider
  import phase_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int T_W         = 8,
  parameter int COEF_W      = 8,
  parameter int STALL_TICKS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              tick_i,
  input  logic [1:0]        enter_i,
  input  logic [1:0]        leave_i,
  input  logic [1:0]        phase_i,
  input  logic              fav_i,
  input  logic [COEF_W-1:0] alpha0_i,
  input  logic [COEF_W-1:0] alpha1_i,
  input  logic [COEF_W-1:0] beta0_i,
  input  logic [COEF_W-1:0] beta1_i,
  input  logic [T_W-1:0]    min0_i,
  input  logic [T_W-1:0]    max0_i,
  input  logic [T_W-1:0]    min1_i,
  input  logic [T_W-1:0]    max1_i,
  input  logic [T_W-1:0]    min_left_i,
  input  logic [T_W-1:0]    max_left_i,
  input  logic [T_W-1:0]    max_ped_i,
  output logic              switch_o,
  output logic [CNT_W-1:0]  count0_o,
  output logic [CNT_W-1:0]  count1_o
);
  localparam int N_ARM = 2;

  logic [CNT_W-1:0] cnt [N_ARM];
  logic [N_ARM-1:0] chg;
  logic [T_W-1:0]   t_cur;
  logic             stall, sw;

  for (genvar g = 0; g < N_ARM; g++) begin : g_arm
    arm_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (clear_i),
      .enter_i  (enter_i[g]),
      .leave_i  (leave_i[g]),
      .count_o  (cnt[g]),
      .changed_o(chg[g])
    );
  end

  phase_timer #(.T_W(T_W), .STALL_TICKS(STALL_TICKS)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .tick_i   (tick_i),
    .restart_i(sw),
    .fav_chg_i(chg[fav_i]),
    .t_o      (t_cur),
    .stall_o  (stall)
  );

  switch_logic #(.CNT_W(CNT_W), .T_W(T_W), .COEF_W(COEF_W), .FRAC_W(4)) i_sw (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .phase_i   (phase_i),
    .fav_i     (fav_i),
    .t_i       (t_cur),
    .stall_i   (stall),
    .n0_i      (cnt[0]),
    .n1_i      (cnt[1]),
    .alpha0_i  (alpha0_i),
    .alpha1_i  (alpha1_i),
    .beta0_i   (beta0_i),
    .beta1_i   (beta1_i),
    .min0_i    (min0_i),
    .max0_i    (max0_i),
    .min1_i    (min1_i),
    .max1_i    (max1_i),
    .min_left_i(min_left_i),
    .max_left_i(max_left_i),
    .max_ped_i (max_ped_i),
    .switch_o  (sw)
  );

  assign switch_o = sw;
  assign count0_o = cnt[0];
  assign count1_o = cnt[1];

  p_clear_counts_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count0_o == '0 && count1_o == '0));
endmodule

// File: tb/test_phase_decider.sv
`timescale 1ns/1ps
module test_phase_decider;
  logic clk_i = 1'b0, rst_ni = 1'b0, clear_i = 1'b0, tick_i = 1'b0;
  logic [1:0] enter_i = '0, leave_i = '0, phase_i = 2'd2;
  logic fav_i = 1'b0;
  logic [7:0] alpha0_i = '0, alpha1_i = '0, beta0_i = '0, beta1_i = '0;
  logic [7:0] min0_i = '0, max0_i = '0, min1_i = '0, max1_i = '0;
  logic [7:0] min_left_i = '0, max_left_i = '0, max_ped_i = 8'd255;
  logic switch_o;
  logic [7:0] count0_o, count1_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  phase_decider i_phase_decider (.*);

  // {alpha, beta, n0, n1, fav, expected switch}
  localparam logic [47:0] VEC [11] = '{
    48'h10_00_03_02_00_00,
    48'h10_00_02_02_00_01,
    48'h08_10_04_03_00_01,
    48'h08_10_04_02_00_00,
    48'hF0_50_02_02_00_00,
    48'hF0_40_02_02_00_01,
    48'h18_F8_05_07_00_01,
    48'h00_00_00_00_00_01,
    48'h20_10_00_00_00_01,
    48'h10_00_02_03_01_00,
    48'h10_00_03_02_01_01
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart();
    @(negedge clk_i);
    phase_i = 2'd2; max_ped_i = 8'd255; clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
  endtask

  task automatic load(input int n0, input int n1);
    for (int i = 0; i < n0; i++) begin
      enter_i[0] = 1'b1; @(negedge clk_i);
    end
    enter_i[0] = 1'b0;
    for (int i = 0; i < n1; i++) begin
      enter_i[1] = 1'b1; @(negedge clk_i);
    end
    enter_i[1] = 1'b0;
  endtask

  // one tick, then sample switch_o where the registered request lands
  task automatic do_tick(output int sw);
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
    @(negedge clk_i); sw = int'(switch_o);
  endtask

  task automatic ticks_none(input int n, input string req);
    int sw;
    for (int i = 0; i < n; i++) begin
      do_tick(sw);
      chk(req, sw, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int sw;
    repeat (3) @(negedge clk_i);
    chk("R11 reset switch", int'(switch_o), 0);
    chk("R11 reset count0", int'(count0_o), 0);
    chk("R11 reset count1", int'(count1_o), 0);
    rst_ni = 1'b1;

    // R7 / R6 vector table, green phase, min 2, max 200
    foreach (VEC[k]) begin
      restart();
      load(int'(VEC[k][31:24]), int'(VEC[k][23:16]));
      alpha0_i = VEC[k][47:40]; alpha1_i = VEC[k][47:40];
      beta0_i  = VEC[k][39:32]; beta1_i  = VEC[k][39:32];
      fav_i = VEC[k][8];
      min0_i = 8'd2; min1_i = 8'd2; max0_i = 8'd200; max1_i = 8'd200;
      phase_i = 2'd0;
      do_tick(sw);
      chk("R4 below min in vector", sw, 0);
      do_tick(sw);
      chk($sformatf("R7/R6 vector %0d", k), sw, int'(VEC[k][0]));
    end

    // R1 counting and simultaneous pulses
    restart();
    load(3, 1);
    chk("R1 count0 after 3 entries", int'(count0_o), 3);
    chk("R1 count1 after 1 entry", int'(count1_o), 1);
    enter_i = 2'b01; leave_i = 2'b11; @(negedge clk_i);
    enter_i = '0; leave_i = '0;
    chk("R1 both pulses arm0", int'(count0_o), 3);
    chk("R1 exit arm1", int'(count1_o), 0);
    // R2 floor
    leave_i[1] = 1'b1; @(negedge clk_i); leave_i[1] = 1'b0;
    chk("R2 floor at zero", int'(count1_o), 0);
    // R11 clear
    clear_i = 1'b1; @(negedge clk_i); clear_i = 1'b0;
    chk("R11 clear count0", int'(count0_o), 0);
    // R2 ceiling
    load(256, 0);
    chk("R2 ceiling", int'(count0_o), 255);

    // R4 minimum hold with empty favoured queue
    restart();
    min0_i = 8'd3; max0_i = 8'd50; fav_i = 1'b0; phase_i = 2'd0;
    ticks_none(2, "R4 hold below min");
    do_tick(sw); chk("R6 empty queue at min", sw, 1);

    // R5 forced at max, R3 pulse width and restart
    restart();
    load(3, 0);
    alpha0_i = 8'h10; beta0_i = 8'h00;
    min0_i = 8'd1; max0_i = 8'd4; phase_i = 2'd0;
    ticks_none(3, "R5 before max");
    do_tick(sw); chk("R5 forced at max", sw, 1);
    @(negedge clk_i); chk("R3 one-cycle pulse", int'(switch_o), 0);
    do_tick(sw); chk("R3 T restarted", sw, 0);

    // R8 stall, with restart on count change
    restart();
    load(3, 0);
    alpha0_i = 8'h10; beta0_i = 8'h00;
    min0_i = 8'd1; max0_i = 8'd50; phase_i = 2'd0;
    ticks_none(3, "R8 before stall");
    @(negedge clk_i); enter_i[0] = 1'b1;
    @(negedge clk_i); enter_i[0] = 1'b0;
    ticks_none(4, "R8 stall restarted by change");
    do_tick(sw); chk("R8 stall switch", sw, 1);

    // R9 left phase bounds, weighted rule ignored
    restart();
    load(3, 10);
    alpha0_i = 8'h00; beta0_i = 8'h00;
    min0_i = 8'd0; max0_i = 8'd0;
    min_left_i = 8'd2; max_left_i = 8'd50; phase_i = 2'd1;
    ticks_none(4, "R9 left ignores green bounds and f");
    do_tick(sw); chk("R9 left stall switch", sw, 1);
    restart();
    load(3, 0);
    min_left_i = 8'd2; max_left_i = 8'd3; phase_i = 2'd1;
    ticks_none(2, "R9 left before max");
    do_tick(sw); chk("R5 left forced at max", sw, 1);

    // R10 pedestrian phase
    restart();
    max_ped_i = 8'd6;
    ticks_none(5, "R10 ped ignores empty queue");
    do_tick(sw); chk("R10 ped at max", sw, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule